// File: doc/BRIEF.md
# MSI-X Capability Header Registers

This block holds the three configuration dwords that announce MSI-X support for a PCI function. Dword 0 carries the capability ID, a next-capability pointer, the encoded vector count and the global MSI-X enable bit. Dwords 1 and 2 tell software where the vector table and the pending-bit array live. Each of them is a BAR indicator in bits 2:0 ORed with a byte offset. Both values are fixed at elaboration from the BAR number and the vector count.

Configuration accesses arrive as single dword writes with byte enables, addressed by a 2-bit dword index. Reads are combinational on the same index. The global enable is driven out to the vector table. The table also receives two one-cycle pulses. The rise pulse tells it to deliver every pending message of an unmasked vector and clear that vector's pending flag. The fall pulse tells it to withdraw every unmasked vector. The block does not sweep the table itself.

Top module: `msix_cap_regs`

## Requirements
- R1: After reset the global enable output is 0 and no enable pulse is asserted.
- R2: Dword 0 reads the capability ID 0x11 in bits 7:0, the next-pointer parameter in bits 15:8, the vector count minus one in bits 26:16 and the global enable in bit 31. All other bits read 0. With 64 vectors and pointer 0 it reads 0x003F0011 while disabled and 0x803F0011 while enabled.
- R3: A write to dword 0 with byte enable bit 3 set loads the global enable from write-data bit 31 at that clock edge. No other write-data bit changes any register.
- R4: A write to dword 0 with byte enable bit 3 clear leaves the global enable unchanged.
- R5: Dword 1 reads the table offset ORed with the BAR number in bits 2:0. With BAR 2 and offset 0 it reads 0x00000002.
- R6: Dword 2 reads (vector count × 16) ORed with the BAR number. With 64 vectors and BAR 2 it reads 0x00000402.
- R7: Writes to dwords 1, 2 and 3 change no readable value and no output.
- R8: A 0-to-1 change of the global enable asserts the rise pulse for exactly the one cycle in which the new value first appears. Writing 1 while already enabled gives no pulse.
- R9: A 1-to-0 change of the global enable asserts the fall pulse for exactly the one cycle in which the new value first appears. Writing 0 while already disabled gives no pulse.
- R10: Dword index 3 reads 0.
- R11: The rise and fall pulses are never asserted together. The global enable output always equals bit 31 of dword 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for one dword |
| cfg_idx | input | 2 | Dword index within the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_idx |
| msix_en | output | 1 | Global MSI-X enable |
| en_rise | output | 1 | One-cycle pulse on an enable 0-to-1 change |
| en_fall | output | 1 | One-cycle pulse on an enable 1-to-0 change |

## Verification
The only state in the block is the enable flag and its edge history. A wrong enable shows on msix_en and in bit 31 of dword 0 in the cycle after the write edge that caused it. A wrong edge history shows up in that same cycle as a missing, doubled or spurious sweep pulse. The location dwords are constants, so a write that disturbs them would show on the next read of that index. The bench reads every index continuously and compares all outputs against its model on every clock, so any such fault is caught within one cycle.

// File: rtl/msix_cap_pkg.sv
package msix_cap_pkg;
  localparam int unsigned DW = 32;
  localparam logic [7:0] MSIX_CAP_ID = 8'h11;
  localparam int unsigned ENTRY_BYTES = 16;

  typedef enum logic [1:0] {
    IDX_CTRL  = 2'd0,
    IDX_TABLE = 2'd1,
    IDX_PBA   = 2'd2,
    IDX_NONE  = 2'd3
  } cap_idx_e;

  typedef struct packed {
    logic        en;
    logic [3:0]  zero_hi;
    logic [10:0] size_m1;
    logic [7:0]  next_ptr;
    logic [7:0]  cap_id;
  } ctrl_dw_t;
endpackage

// File: rtl/msix_cap_loc.sv
module msix_cap_loc #(
  parameter int unsigned BAR_NUM = 2,
  parameter int unsigned OFFSET  = 0
) (
  output logic [31:0] loc_dw
);
  localparam logic [31:0] OFS_W = 32'(OFFSET);
  localparam logic [2:0]  BAR_W = 3'(BAR_NUM);

  generate
    if (BAR_NUM > 5) begin : g_bad_bar
      $fatal(1, "BAR number must be below 6");
    end
    if ((OFFSET % 8) != 0) begin : g_bad_ofs
      $fatal(1, "location offset must be 8-byte aligned");
    end
  endgenerate

  always_comb begin
    loc_dw = OFS_W;
    loc_dw[2:0] = BAR_W;
  end
endmodule

// File: rtl/msix_cap_enable.sv
module msix_cap_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  output logic en,
  output logic rise,
  output logic fall
);
  logic en_q, en_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;

  always_comb begin
    en_d   = en_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (load) begin
      en_d   = load_val;
      rise_d = load_val & ~en_q;
      fall_d = ~load_val & en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign en   = en_q;
  assign rise = rise_q;
  assign fall = fall_q;
endmodule

// File: rtl/msix_cap_rdmux.sv
module msix_cap_rdmux
  import msix_cap_pkg::*;
(
  input  logic [1:0]  idx,
  input  ctrl_dw_t    ctrl,
  input  logic [31:0] table_dw,
  input  logic [31:0] pba_dw,
  output logic [31:0] rdata
);
  always_comb begin
    unique case (cap_idx_e'(idx))
      IDX_CTRL:  rdata = ctrl;
      IDX_TABLE: rdata = table_dw;
      IDX_PBA:   rdata = pba_dw;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/msix_cap_regs.sv
module msix_cap_regs
  import msix_cap_pkg::*;
#(
  parameter int unsigned VEC_COUNT = 64,
  parameter int unsigned BAR_NUM   = 2,
  parameter int unsigned TABLE_OFS = 0,
  parameter logic [7:0]  NEXT_PTR  = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_idx,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        msix_en,
  output logic        en_rise,
  output logic        en_fall
);
  localparam int unsigned PBA_OFS = VEC_COUNT * ENTRY_BYTES;
  localparam logic [10:0] SIZE_M1 = 11'(VEC_COUNT - 1);

  generate
    if (VEC_COUNT < 1 || VEC_COUNT > 2048) begin : g_bad_cnt
      $fatal(1, "vector count must be 1..2048");
    end
  endgenerate

  logic        ctrl_load;
  logic [31:0] table_dw, pba_dw;
  ctrl_dw_t    ctrl;

  assign ctrl_load = cfg_wr && (cfg_idx == IDX_CTRL) && cfg_be[3];

  msix_cap_enable u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctrl_load),
    .load_val (cfg_wdata[31]),
    .en       (msix_en),
    .rise     (en_rise),
    .fall     (en_fall)
  );

  msix_cap_loc #(.BAR_NUM(BAR_NUM), .OFFSET(TABLE_OFS)) u_tbl (.loc_dw(table_dw));
  msix_cap_loc #(.BAR_NUM(BAR_NUM), .OFFSET(PBA_OFS))   u_pba (.loc_dw(pba_dw));

  always_comb begin
    ctrl          = '0;
    ctrl.cap_id   = MSIX_CAP_ID;
    ctrl.next_ptr = NEXT_PTR;
    ctrl.size_m1  = SIZE_M1;
    ctrl.en       = msix_en;
  end

  msix_cap_rdmux u_mux (
    .idx      (cfg_idx),
    .ctrl     (ctrl),
    .table_dw (table_dw),
    .pba_dw   (pba_dw),
    .rdata    (cfg_rdata)
  );
endmodule

// File: rtl/msix_cap_regs_chk.sv
module msix_cap_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [1:0]  cfg_idx,
  input logic [3:0]  cfg_be,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        msix_en,
  input logic        en_rise,
  input logic        en_fall
);
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_idx == 2'd0 && cfg_be[3]) |=> (msix_en == $past(cfg_wdata[31]))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_idx == 2'd0 && cfg_be[3]) |=> $stable(msix_en)); // R4
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |-> (msix_en && !$past(msix_en))); // R8
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |-> (!msix_en && $past(msix_en))); // R9
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_rise && en_fall)); // R11
  AST_BIT31_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx == 2'd0) |-> (cfg_rdata[31] == msix_en)); // R11
  AST_LOC_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_idx != 2'd0 && cfg_idx == $past(cfg_idx)) |-> $stable(cfg_rdata)); // R7
endmodule

bind msix_cap_regs msix_cap_regs_chk u_chk (.*);

// File: tb/msix_cap_regs_test.sv
module msix_cap_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_idx = 2'd0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        msix_en, en_rise, en_fall;

  int checks = 0;
  int errors = 0;
  string req = "R1";

  bit m_en = 0, m_rise = 0, m_fall = 0;

  always #2.5 clk = ~clk;

  msix_cap_regs uut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_rise <= 0; m_fall <= 0;
    end else begin
      m_rise <= 0; m_fall <= 0;
      if (cfg_wr && cfg_idx == 0 && cfg_be[3]) begin
        m_en   <= cfg_wdata[31];
        m_rise <= cfg_wdata[31] && !m_en;
        m_fall <= !cfg_wdata[31] && m_en;
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] i, input bit en);
    case (i)
      2'd0: return {en, 4'h0, 11'd63, 8'h00, 8'h11};
      2'd1: return 32'h0000_0002;
      2'd2: return 32'h0000_0402;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({req, " rdata"}, cfg_rdata, exp_rd(cfg_idx, m_en));
    chk("R11 en", {31'd0, msix_en}, {31'd0, m_en});
    chk("R8 rise", {31'd0, en_rise}, {31'd0, m_rise});
    chk("R9 fall", {31'd0, en_fall}, {31'd0, m_fall});
  end

  task automatic wr(input logic [1:0] i, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = i; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic rd(input logic [1:0] i);
    @(negedge clk);
    cfg_idx = i;
    @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk("R1 en", {31'd0, msix_en}, 32'd0);
        chk("R1 pulses", {30'd0, en_rise, en_fall}, 32'd0);
        req = "R2"; rd(0);
        #1 chk("R2 disabled", cfg_rdata, 32'h003F_0011);
        req = "R5"; rd(1);
        req = "R6"; rd(2);
        req = "R10"; rd(3);
        req = "R3"; wr(0, 4'hF, 32'hFFFF_FFFF);
        #1 chk("R8 rise seen", {31'd0, en_rise}, 32'd1);
        req = "R2"; rd(0);
        #1 chk("R2 enabled", cfg_rdata, 32'h803F_0011);
        req = "R8"; wr(0, 4'h8, 32'h8000_0000);
        req = "R4"; wr(0, 4'h7, 32'h0000_0000);
        rd(0);
        #1 chk("R4 held", {31'd0, msix_en}, 32'd1);
        req = "R9"; wr(0, 4'h8, 32'h7FFF_FFFF);
        #1 chk("R9 fall seen", {31'd0, en_fall}, 32'd1);
        wr(0, 4'hF, 32'h0);
        req = "R7"; wr(1, 4'hF, 32'hFFFF_FFFF);
        wr(2, 4'hF, 32'h8000_0000);
        wr(3, 4'hF, 32'h8000_0000);
        rd(1); rd(2);
        #1 chk("R7 no enable", {31'd0, msix_en}, 32'd0);
        req = "R3"; wr(0, 4'h8, 32'h8000_0000);
        wr(0, 4'h8, 32'h0);
        wr(0, 4'h8, 32'h8000_0000);
        rd(0); rd(3);
        repeat (3) @(negedge clk);
      end
      begin
        repeat (10000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual hung expected done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule